// File: doc/BRIEF.md
# Justified Serial Audio Receiver

This block deserializes stereo PCM from a three-wire serial audio link: a frame clock that marks which channel is on the wire, a bit clock, and one data line. The whole block runs on the bit clock. Every rising bit-clock edge samples the frame clock and the data line. A change in the sampled frame clock level starts a new channel half-frame.

Two framing modes are selectable. In the first, the sample starts right at the head of the half-frame. In the second, each half-frame is exactly 32 bit clocks long and the sample ends on its last clock. A 2-bit select sets the sample length to 16, 18, 20 or 24 bits. Each completed stereo pair is presented as two left-aligned 24-bit words, marked by a one-cycle valid strobe. Bits outside the sample window in each half-frame are ignored. The mode and width inputs are treated as static while frames are flowing.

Top module: `justified_rx`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `leftWord` and `rightWord` read zero and `pairValid` is low.
- R2: A sampled `frameClk` level of 0 marks the left channel and 1 marks the right channel. The two words of one pair are always presented together, with the left half-frame's sample on `leftWord`.
- R3: With `rightJustMode` = 0, the MSB is the data bit sampled at the first rising edge where `frameClk` differs from its previous sampled level. The next W-1 edges carry the rest of the bits, MSB first. Later bits in the half-frame are ignored.
- R4: With `rightJustMode` = 1, a half-frame is 32 bit clocks long. The LSB is sampled at the 32nd edge (position 31, counting the transition edge as position 0) and the MSB at position 32-W. Bits at positions before 32-W are ignored.
- R5: `widthSel` encodes W as 0→16, 1→18, 2→20, 3→24. The sample is left-aligned in the 24-bit word: sample bit W-1 lands in word bit 23, and the 24-W low bits are zero.
- R6: `pairValid` is high for exactly one cycle. It rises after the rising edge at which the right-to-left `frameClk` transition is sampled, and the new words appear in that same cycle.
- R7: No pair is reported until a left half-frame and the following right half-frame have both started at an observed `frameClk` transition since reset. The partial frame right after reset produces no output.
- R8: While `pairValid` is low, `leftWord` and `rightWord` hold their values, including when `frameClk` stays at one level indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameClk | input | 1 | Frame clock: 0 = left half-frame, 1 = right half-frame |
| serialData | input | 1 | Serial sample data, MSB first |
| rightJustMode | input | 1 | 0 = sample at head of half-frame, 1 = sample at tail of 32-clock half-frame |
| widthSel | input | 2 | Sample length: 0=16, 1=18, 2=20, 3=24 bits |
| leftWord | output | 24 | Left sample, left-aligned, low bits zero |
| rightWord | output | 24 | Right sample, left-aligned, low bits zero |
| pairValid | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A bit-position counter that is off by one shifts every received word by one bit. Such an error shows on the very first reported pair, either as a doubled value or as a stray junk bit at the LSB, because the bench fills every bit outside the sample window with random data. A wrong channel-sync flag shows as a spurious `pairValid` during the start-up frame, or as a missing one after it, so the pulse count exposes it one frame after reset. A broken word latch shows as words changing while the strobe is low. The hold checks catch that within a frame.

// File: rtl/jrx_pkg.sv
`timescale 1ns/1ps
package jrx_pkg;

  localparam int SAMPLE_MAX = 24;
  localparam int HALF_LEN   = 32;

  // Strobes from control to datapath, all valid in the current bit-clock cycle.
  typedef struct packed {
    logic halfStart;   // a frame-clock transition was sampled this edge
    logic capture;     // current data bit lies inside the sample window
    logic latchLeft;   // left half-frame just ended after a synced start
    logic latchPair;   // right half-frame just ended; pair is complete
  } rxStrobes_t;

  typedef enum logic [1:0] {
    WIDTH_16 = 2'd0,
    WIDTH_18 = 2'd1,
    WIDTH_20 = 2'd2,
    WIDTH_24 = 2'd3
  } widthCode_t;

  function automatic int sampleBits(input logic [1:0] sel);
    case (widthCode_t'(sel))
      WIDTH_16: return 16;
      WIDTH_18: return 18;
      WIDTH_20: return 20;
      default:  return 24;
    endcase
  endfunction

endpackage

// File: rtl/jrx_ctrl.sv
`timescale 1ns/1ps
module jrx_ctrl
  import jrx_pkg::*;
#(
  parameter int HALF_CLKS = HALF_LEN
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic       rightJustMode,
  input  logic [1:0] widthSel,
  output rxStrobes_t strb
);

  localparam int CNT_W = $clog2(HALF_CLKS) + 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(HALF_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF_V   = CNT_W'(HALF_CLKS);
  localparam logic [CNT_W-1:0] POS_SAT  = {CNT_W{1'b1}};

  logic             prevFrame;
  logic [CNT_W-1:0] posReg;
  logic [CNT_W-1:0] posNow;
  logic [CNT_W-1:0] widthBits;
  logic [CNT_W-1:0] rjStart;
  logic             transition;
  logic             halfSynced;
  logic             leftOk;
  logic             inWindow;

  assign transition = frameClk ^ prevFrame;
  assign widthBits  = CNT_W'(sampleBits(widthSel));
  assign rjStart    = HALF_V - widthBits;

  // Position of the bit sampled at this edge within the half-frame.
  always_comb begin
    if (transition)            posNow = '0;
    else if (posReg == POS_SAT) posNow = POS_SAT;
    else                        posNow = posReg + 1'b1;
  end

  always_comb begin
    if (rightJustMode) inWindow = (posNow >= rjStart) && (posNow <= LAST_POS);
    else               inWindow = (posNow < widthBits);
  end

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      prevFrame  <= 1'b0;
      posReg     <= POS_SAT;
      halfSynced <= 1'b0;
      leftOk     <= 1'b0;
    end else begin
      prevFrame <= frameClk;
      posReg    <= posNow;
      if (transition) begin
        halfSynced <= 1'b1;
        if (frameClk) leftOk <= halfSynced;  // left half just closed
        else          leftOk <= 1'b0;        // pair closed; new left starts
      end
    end
  end

  always_comb begin
    strb.halfStart = transition;
    strb.capture   = inWindow;
    strb.latchLeft = transition && frameClk && halfSynced;
    strb.latchPair = transition && !frameClk && halfSynced && leftOk;
  end

endmodule

// File: rtl/jrx_datapath.sv
`timescale 1ns/1ps
module jrx_datapath
  import jrx_pkg::*;
#(
  parameter int WORD_W = SAMPLE_MAX
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serialData,
  input  logic [1:0]        widthSel,
  input  rxStrobes_t        strb,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid
);

  localparam int SH_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shiftAcc;
  logic [WORD_W-1:0] leftHold;
  logic [WORD_W-1:0] alignedWord;
  logic [SH_W-1:0]   padBits;

  // Number of zero bits below a W-bit sample inside the output word.
  assign padBits     = SH_W'(WORD_W) - SH_W'(sampleBits(widthSel));
  assign alignedWord = shiftAcc << padBits;

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      shiftAcc  <= '0;
      leftHold  <= '0;
      leftWord  <= '0;
      rightWord <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= strb.latchPair;
      if (strb.latchLeft) leftHold <= alignedWord;
      if (strb.latchPair) begin
        leftWord  <= leftHold;
        rightWord <= alignedWord;
      end
      if (strb.halfStart)
        shiftAcc <= strb.capture ? {{(WORD_W-1){1'b0}}, serialData} : '0;
      else if (strb.capture)
        shiftAcc <= {shiftAcc[WORD_W-2:0], serialData};
    end
  end

endmodule

// File: rtl/justified_rx.sv
`timescale 1ns/1ps
module justified_rx
  import jrx_pkg::*;
#(
  parameter int WORD_W    = SAMPLE_MAX,
  parameter int HALF_CLKS = HALF_LEN
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              frameClk,
  input  logic              serialData,
  input  logic              rightJustMode,
  input  logic [1:0]        widthSel,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid
);

  rxStrobes_t strb;

  jrx_ctrl #(.HALF_CLKS(HALF_CLKS)) i_ctrl (
    .bitClk        (bitClk),
    .rstN          (rstN),
    .frameClk      (frameClk),
    .rightJustMode (rightJustMode),
    .widthSel      (widthSel),
    .strb          (strb)
  );

  jrx_datapath #(.WORD_W(WORD_W)) i_dp (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .serialData (serialData),
    .widthSel   (widthSel),
    .strb       (strb),
    .leftWord   (leftWord),
    .rightWord  (rightWord),
    .pairValid  (pairValid)
  );

endmodule

// File: rtl/justified_rx_checker.sv
`timescale 1ns/1ps
module justified_rx_checker
  import jrx_pkg::*;
#(
  parameter int WORD_W = SAMPLE_MAX
) (
  input logic              bitClk,
  input logic              rstN,
  input logic              frameClk,
  input logic [1:0]        widthSel,
  input logic [WORD_W-1:0] leftWord,
  input logic [WORD_W-1:0] rightWord,
  input logic              pairValid
);

  logic             chkPrev;
  logic [1:0]       transSeen;
  logic [WORD_W-1:0] lowMask;

  always_comb lowMask = (WORD_W'(1) << (WORD_W - sampleBits(widthSel))) - 1'b1;

  always_ff @(posedge bitClk) begin
    if (!rstN) begin
      chkPrev   <= 1'b0;
      transSeen <= 2'd0;
    end else begin
      chkPrev <= frameClk;
      if ((frameClk != chkPrev) && (transSeen != 2'd3)) transSeen <= transSeen + 2'd1;
    end
  end

  p_reset_r1: assert property (@(posedge bitClk)
    !rstN |=> (!pairValid && leftWord == '0 && rightWord == '0));

  p_single_pulse_r6: assert property (@(posedge bitClk) disable iff (!rstN)
    pairValid |=> !pairValid);

  p_hold_words_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    !pairValid |-> ($stable(leftWord) && $stable(rightWord)));

  p_zero_fill_r5: assert property (@(posedge bitClk) disable iff (!rstN)
    ((leftWord & lowMask) == '0) && ((rightWord & lowMask) == '0));

  p_synced_start_r7: assert property (@(posedge bitClk) disable iff (!rstN)
    pairValid |-> (transSeen == 2'd3));

endmodule

bind justified_rx justified_rx_checker #(.WORD_W(WORD_W)) i_chk (
  .bitClk    (bitClk),
  .rstN      (rstN),
  .frameClk  (frameClk),
  .widthSel  (widthSel),
  .leftWord  (leftWord),
  .rightWord (rightWord),
  .pairValid (pairValid)
);

// File: tb/test_justified_rx.sv
`timescale 1ns/1ps
module test_justified_rx;

  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameClk = 1'b0;
  logic        serialData = 1'b0;
  logic        rightJustMode = 1'b0;
  logic [1:0]  widthSel = 2'd3;
  logic [23:0] leftWord;
  logic [23:0] rightWord;
  logic        pairValid;

  int checks = 0;
  int errors = 0;
  int rxCount = 0;
  logic [23:0] rxL [0:15];
  logic [23:0] rxR [0:15];
  logic [23:0] expL [0:15];
  logic [23:0] expR [0:15];

  always #2.5 bitClk = ~bitClk;

  justified_rx i_justified_rx (
    .bitClk(bitClk), .rstN(rstN), .frameClk(frameClk), .serialData(serialData),
    .rightJustMode(rightJustMode), .widthSel(widthSel),
    .leftWord(leftWord), .rightWord(rightWord), .pairValid(pairValid)
  );

  // Record every reported pair, sampled away from the active edge.
  always @(negedge bitClk) begin
    if (rstN && pairValid && rxCount < 16) begin
      rxL[rxCount] = leftWord;
      rxR[rxCount] = rightWord;
      rxCount++;
    end else if (rstN && pairValid) begin
      rxCount++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  // Drive one 32-clock half-frame; slots outside the window carry random junk.
  task automatic sendHalf(input logic level, input logic [23:0] s, input int w, input logic rj);
    for (int j = 0; j < 32; j++) begin
      @(negedge bitClk);
      frameClk = level;
      if (rj) serialData = (j >= 32 - w) ? s[31 - j] : 1'($urandom);
      else    serialData = (j < w) ? s[w - 1 - j] : 1'($urandom);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    frameClk = 1'b0;
    serialData = 1'b0;
    repeat (4) @(negedge bitClk);
    check(!pairValid && leftWord == 24'h0 && rightWord == 24'h0, "R1 reset state",
          leftWord, 24'h0);
    @(negedge bitClk);
    rstN = 1'b1;
    rxCount = 0;
  endtask

  // One scenario: reset, a priming frame, N checked frames, then idle hold.
  task automatic runScenario(input logic rj, input logic [1:0] ws, input int nFrames);
    int w;
    logic [23:0] mask;
    logic [23:0] sL, sR;
    rightJustMode = rj;
    widthSel = ws;
    doReset();
    w = bitsOf(ws);
    mask = (24'h1 << w) - 24'h1;
    if (w == 24) mask = 24'hFFFFFF;
    sendHalf(1'b0, 24'($urandom) & mask, w, rj);
    sendHalf(1'b1, 24'($urandom) & mask, w, rj);
    for (int f = 0; f < nFrames; f++) begin
      sL = 24'($urandom) & mask;
      sR = 24'($urandom) & mask;
      expL[f] = sL << (24 - w);
      expR[f] = sR << (24 - w);
      sendHalf(1'b0, sL, w, rj);
      if (f == 0) check(rxCount == 0, "R7 no pair from start-up frame", 24'(rxCount), 24'h0);
      sendHalf(1'b1, sR, w, rj);
    end
    // Flush: right-to-left transition closes the last pair, then hold low.
    repeat (3) begin
      @(negedge bitClk);
      frameClk = 1'b0;
      serialData = 1'($urandom);
    end
    check(rxCount == nFrames, "R6 one pulse per pair", 24'(rxCount), 24'(nFrames));
    for (int f = 0; f < nFrames && f < 16; f++) begin
      check(rxL[f] == expL[f], rj ? "R4 R5 R2 left word" : "R3 R5 R2 left word", rxL[f], expL[f]);
      check(rxR[f] == expR[f], rj ? "R4 R5 R2 right word" : "R3 R5 R2 right word", rxR[f], expR[f]);
    end
    repeat (40) @(negedge bitClk);
    check(!pairValid && rxCount == nFrames, "R8 no pulse while frame clock idle",
          24'(rxCount), 24'(nFrames));
    check(leftWord == expL[nFrames-1] && rightWord == expR[nFrames-1], "R8 words held",
          leftWord, expL[nFrames-1]);
  endtask

  // Single-cycle strobe: sample one cycle after the pulse is seen.
  task automatic checkPulseWidth();
    int highCycles = 0;
    rightJustMode = 1'b0;
    widthSel = 2'd3;
    doReset();
    fork
      begin
        for (int c = 0; c < 64 * 4 + 8; c++) begin
          @(negedge bitClk);
          if (pairValid) highCycles++;
        end
      end
      begin
        for (int f = 0; f < 4; f++) begin
          sendHalf(1'b0, 24'($urandom), 24, 1'b0);
          sendHalf(1'b1, 24'($urandom), 24, 1'b0);
        end
        @(negedge bitClk);
        frameClk = 1'b0;
      end
    join
    check(highCycles == 3, "R6 strobe high one cycle per pair", 24'(highCycles), 24'd3);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int ws = 0; ws < 4; ws++)
        runScenario(1'(m), 2'(ws), 4);
    checkPulseWidth();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule